// File: doc/BRIEF.md
# Stop-State Wake and Clock Supervisor

This block decides when a microcontroller may run again after it has left a low-power stop state or come out of power-on reset. It also watches an external sampled clock for failure. A single option byte, written by strobe, sets four behaviours: long or short resume count, clock supervision on or off, a force bit that turns supervision on permanently, and falling-edge or low-level sensitivity on the interrupt pin.

The `resume` output is high while the core may execute. A `stop_req` pulse while running drops `resume` and parks the block. Only an interrupt request or a reset brings it out again. Each wake starts a fresh count, either 4064 cycles or 4 cycles, and `resume` rises when the count ends. The clock supervisor counts bus cycles since the last transition of `mon_clk`. When that count passes a threshold it raises `cfail_req`, which the chip's reset logic consumes.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it, `opt_q` reads 8'h01, `resume` is 0, and `irq_req` and `cfail_req` are 0.
- R2: With option bit 0 set to 1 at the moment of wake, `resume` rises exactly 4064 cycles after the wake is accepted. The reset release counts as a wake with bit 0 set, so the first rising edge after reset release is cycle 1 and `resume` is high after edge 4064.
- R3: With option bit 0 set to 0 at the moment of wake, `resume` rises exactly 4 cycles after the wake is accepted.
- R4: Option bit 2 (force supervision) is set by writing 1. Writing 0 to it has no effect. Only `rst_n` clears it.
- R5: Supervision is active when option bit 2 or option bit 1 is 1. If active and `mon_clk` shows no transition, `cfail_req` rises on the (MON_LIMIT+1)-th edge after activation. A clock that toggles at least every MON_LIMIT/2 cycles never raises it. While inactive, `cfail_req` stays 0.
- R6: A `stop_req` pulse while `resume` is high drops `resume` and raises `stopped` at the next edge. `stop_req` is ignored while counting. The stopped state persists until `irq_req` is 1.
- R7: With option bit 3 set to 1 (edge mode), a falling edge on `irq_n` sets a pending request. The request is visible on `irq_req` after the third edge and stays until `irq_clr`. A new edge and a clear in the same cycle leave it set. A wake from stop in this mode gives `resume` N+4 cycles after the pin falls.
- R8: With option bit 3 set to 0 (level mode), `irq_req` follows the inverted pin after two edges. A wake from stop in this mode gives `resume` N+3 cycles after the pin falls.
- R9: A write stores the whole data byte in `opt_q`, except that bit 2 is ORed with its old value. Bit 0 is the delay select, bit 1 is the supervision enable, bit 2 is the force bit and bit 3 is the edge select. Bits 7..4 are spare and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Option byte write strobe |
| wr_data | input | 8 | Option byte write data |
| opt_q | output | 8 | Current option byte |
| stop_req | input | 1 | Request to enter the stop state |
| irq_n | input | 1 | Active-low interrupt pin, asynchronous |
| irq_clr | input | 1 | Clears the pending edge request |
| mon_clk | input | 1 | Sampled clock under supervision |
| resume | output | 1 | Core may execute |
| stopped | output | 1 | Block is in the stop state |
| irq_req | output | 1 | Conditioned interrupt request |
| cfail_req | output | 1 | Clock failure reset request |

## Verification
In edge mode, a freshly detected falling edge and an `irq_clr` strobe can land on the same clock edge, and the pending request must survive. The bench first leaves a request pending. It then lowers the pin again and raises `irq_clr` for exactly the third edge after the fall, which is the edge where the detector sets the request. It checks that `irq_req` is still 1 afterwards. A clear on its own must then drop the request.

// File: rtl/swc_pkg.sv
// Shared types for the stop-state wake and clock supervisor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package swc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2
    } swc_state_e;

    typedef struct packed {
        logic long_dly;
        logic mon_en;
        logic mon_force;
        logic edge_sel;
    } swc_opt_t;

endpackage

// File: rtl/swc_opt_reg.sv
// Option byte. Stores the whole write byte and makes the force bit sticky
// until reset. Decodes the four control fields at parameterized positions.
// Assumes the bit positions are distinct and below DATA_W.
module swc_opt_reg
    import swc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIT_DLY   = 0,
    parameter int BIT_MEN   = 1,
    parameter int BIT_FORCE = 2,
    parameter int BIT_EDGE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] opt_q,
    output swc_opt_t          opt
);

    localparam logic [DATA_W-1:0] RST_VAL    = DATA_W'(1) << BIT_DLY;
    localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(1) << BIT_FORCE;

    logic [DATA_W-1:0] q;

    // Register update: load on strobe, force bit only accumulates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_en) begin
            q <= wr_data | (q & FORCE_MASK);
        end
    end

    // Field decode for the rest of the block.
    always_comb begin
        opt_q          = q;
        opt.long_dly   = q[BIT_DLY];
        opt.mon_en     = q[BIT_MEN];
        opt.mon_force  = q[BIT_FORCE];
        opt.edge_sel   = q[BIT_EDGE];
    end

    a_r4_force_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        opt.mon_force |=> opt.mon_force);

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(opt_q));

endmodule

// File: rtl/swc_resume_timer.sv
// Run / stop / wait sequencer. A wake from stop or reset starts a count of
// LONG_CNT or SHORT_CNT cycles. The choice is latched when the wake is
// accepted. Assumes SHORT_CNT >= 1 and LONG_CNT >= SHORT_CNT.
module swc_resume_timer
    import swc_pkg::*;
#(
    parameter int LONG_CNT  = 4064,
    parameter int SHORT_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sel,
    input  logic stop_req,
    input  logic wake,
    output logic resume,
    output logic stopped
);

    localparam int CW = $clog2(LONG_CNT + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CNT - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CNT - 1);

    swc_state_e    st;
    logic [CW-1:0] cnt;
    logic          lim_long;
    logic [CW-1:0] last;

    // Terminal count for the delay chosen at wake time.
    always_comb last = lim_long ? LONG_LAST : SHORT_LAST;

    // Sequencer: reset behaves as a wake with the long delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_WAIT;
            cnt      <= '0;
            lim_long <= 1'b1;
        end else begin
            case (st)
                ST_RUN: begin
                    cnt <= '0;
                    if (stop_req) st <= ST_STOP;
                end
                ST_STOP: begin
                    cnt <= '0;
                    if (wake) begin
                        st       <= ST_WAIT;
                        lim_long <= long_sel;
                    end
                end
                ST_WAIT: begin
                    if (cnt == last) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    // Status outputs.
    always_comb begin
        resume  = (st == ST_RUN);
        stopped = (st == ST_STOP);
    end

    a_r6_stop_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) && !wake |=> (st == ST_STOP));

    a_r6_run_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) && !stop_req |=> (st == ST_RUN));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (cnt <= LONG_LAST));

endmodule

// File: rtl/swc_clk_monitor.sv
// Clock supervisor. Synchronizes mon_clk and counts bus cycles since its
// last transition. Flags failure once the count passes LIMIT. Assumes
// mon_clk is much slower than clk.
module swc_clk_monitor #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic active,
    output logic fail
);

    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

    logic [2:0]    sync;
    logic          edge_seen;
    logic [CW-1:0] gap;

    // Synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= '0;
        else        sync <= {sync[1:0], mon_clk};
    end

    always_comb edge_seen = sync[2] ^ sync[1];

    // Saturating gap counter, cleared when idle or on a transition.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || edge_seen) gap <= '0;
        else if (gap != SAT)                gap <= gap + 1'b1;
    end

    always_comb fail = active && (gap == SAT);

    a_r5_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        active && edge_seen |=> !fail);

    a_r5_rise_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(active) && !$past(edge_seen));

endmodule

// File: rtl/swc_irq_cond.sv
// Interrupt pin conditioner. A two-flop synchronizer is followed by a
// falling-edge detector with a pending latch. Level mode passes the
// synchronized pin through. Assumes irq_n is asynchronous and active low.
module swc_irq_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic edge_sel,
    input  logic clr,
    output logic req
);

    logic [2:0] s;
    logic       fall;
    logic       pend;

    // Synchronizer and history stage, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) s <= '1;
        else        s <= {s[1:0], irq_n};
    end

    always_comb fall = s[2] & ~s[1];

    // Pending latch: a new edge wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~clr) | fall;
    end

    always_comb req = edge_sel ? pend : ~s[1];

    a_r7_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr |=> pend);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !fall |=> !pend);

endmodule

// File: rtl/stop_wake_ctrl.sv
// Top level: option byte, resume sequencer, clock supervisor and interrupt
// conditioner. Assumes a single bus clock and synchronous active-low reset.
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LONG_CNT  = 4064,
    parameter int SHORT_CNT = 4,
    parameter int MON_LIMIT = 64,
    parameter int BIT_DLY   = 0,
    parameter int BIT_MEN   = 1,
    parameter int BIT_FORCE = 2,
    parameter int BIT_EDGE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] opt_q,
    input  logic              stop_req,
    input  logic              irq_n,
    input  logic              irq_clr,
    input  logic              mon_clk,
    output logic              resume,
    output logic              stopped,
    output logic              irq_req,
    output logic              cfail_req
);

    swc_opt_t opt;
    logic     mon_active;

    swc_opt_reg #(
        .DATA_W(DATA_W), .BIT_DLY(BIT_DLY), .BIT_MEN(BIT_MEN),
        .BIT_FORCE(BIT_FORCE), .BIT_EDGE(BIT_EDGE)
    ) u_opt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .opt_q(opt_q), .opt(opt)
    );

    swc_irq_cond u_irq (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .edge_sel(opt.edge_sel),
        .clr(irq_clr), .req(irq_req)
    );

    swc_resume_timer #(
        .LONG_CNT(LONG_CNT), .SHORT_CNT(SHORT_CNT)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .long_sel(opt.long_dly), .stop_req(stop_req),
        .wake(irq_req), .resume(resume), .stopped(stopped)
    );

    // Supervision is on when forced or enabled.
    always_comb mon_active = opt.mon_force | opt.mon_en;

    swc_clk_monitor #(
        .LIMIT(MON_LIMIT)
    ) u_mon (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .active(mon_active),
        .fail(cfail_req)
    );

    a_r6_exclusive_state: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume && stopped));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_q[BIT_FORCE] && !opt_q[BIT_MEN] |-> !cfail_req);

endmodule

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;

    localparam int LONG_N  = 4064;
    localparam int SHORT_N = 4;
    localparam int LIMIT   = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] opt_q;
    logic       stop_req = 1'b0;
    logic       irq_n = 1'b1;
    logic       irq_clr = 1'b0;
    logic       mon_clk = 1'b0;
    logic       resume, stopped, irq_req, cfail_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stop_wake_ctrl u_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .opt_q(opt_q), .stop_req(stop_req), .irq_n(irq_n), .irq_clr(irq_clr),
        .mon_clk(mon_clk), .resume(resume), .stopped(stopped),
        .irq_req(irq_req), .cfail_req(cfail_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wake_cycles(input bit long_d, input bit edge_m);
        return (long_d ? LONG_N : SHORT_N) + (edge_m ? 4 : 3);
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic go_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        chk(stopped && !resume, "R6 enter stop", int'(stopped), 1);
    endtask

    task automatic count_resume(output int n);
        n = 0;
        while (n < 9000) begin
            @(negedge clk); n++;
            if (resume) break;
        end
    endtask

    task automatic count_fail(output int n);
        n = 0;
        while (n < 400) begin
            @(negedge clk); n++;
            if (cfail_req) break;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit f;
        logic [7:0] d;
        void'($urandom(32'd1234));

        repeat (5) @(negedge clk);
        chk(opt_q == 8'h01, "R1 reset opt_q", opt_q, 1);
        chk(!resume && !irq_req && !cfail_req, "R1 reset outputs",
            {resume, irq_req, cfail_req}, 0);

        // R2 power-on long delay, with an ignored stop request (R6) in the count
        rst_n = 1'b1;
        n = 0;
        while (n < 9000) begin
            @(negedge clk); n++;
            stop_req = (n == 10);
            if (resume) break;
        end
        stop_req = 1'b0;
        chk(n == LONG_N, "R2 power-on delay (stop ignored, R6)", n, LONG_N);

        // R9 layout, R8 level mode, R3 short delay
        wr(8'h00);
        chk(opt_q == 8'h00, "R9 write readback", opt_q, 0);
        go_stop();
        repeat (50) @(negedge clk);
        chk(stopped && !resume, "R6 stop persists", int'(stopped), 1);
        irq_n = 1'b0;
        count_resume(n);
        chk(n == wake_cycles(0, 0), "R3 R8 short level wake", n, wake_cycles(0, 0));
        irq_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!irq_req, "R8 level follows pin", irq_req, 0);

        // R7 edge mode wake
        wr(8'h08);
        pulse_clr();
        go_stop();
        irq_n = 1'b0;
        count_resume(n);
        chk(n == wake_cycles(0, 1), "R7 edge wake", n, wake_cycles(0, 1));
        irq_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(irq_req, "R7 pending held", irq_req, 1);
        pulse_clr();
        chk(!irq_req, "R7 clear", irq_req, 0);

        // R7 new edge and clear coincide: set wins
        irq_n = 1'b0; repeat (5) @(negedge clk);
        irq_n = 1'b1; repeat (5) @(negedge clk);
        irq_n = 1'b0;
        @(negedge clk); @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_req, "R7 set beats clear", irq_req, 1);
        irq_n = 1'b1; repeat (4) @(negedge clk);
        pulse_clr();
        chk(!irq_req, "R7 clear after coincidence", irq_req, 0);

        // R2 long wake from stop
        wr(8'h09);
        go_stop();
        irq_n = 1'b0;
        count_resume(n);
        chk(n == wake_cycles(1, 1), "R2 long edge wake", n, wake_cycles(1, 1));
        irq_n = 1'b1; repeat (4) @(negedge clk);
        pulse_clr();

        // R5 supervisor: stuck clock, toggling clock, disabled
        wr(8'h0B);
        count_fail(n);
        chk(n == LIMIT + 1, "R5 stuck clock detect", n, LIMIT + 1);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (i % 8 == 0) mon_clk = ~mon_clk;
            if (i > 20 && cfail_req) n++;
        end
        chk(n == 0, "R5 toggling clock no fail", n, 0);
        wr(8'h01);
        chk(!cfail_req, "R5 disable clears", cfail_req, 0);
        n = 0;
        repeat (200) begin
            @(negedge clk);
            if (cfail_req) n++;
        end
        chk(n == 0, "R5 inactive quiet", n, 0);

        // R4 force bit sticky and overriding
        wr(8'h05);
        count_fail(n);
        chk(n == LIMIT + 1, "R5 forced detect", n, LIMIT + 1);
        wr(8'h01);
        chk(opt_q == 8'h05, "R4 force not cleared", opt_q, 5);
        chk(cfail_req, "R4 forced stays active", cfail_req, 1);

        // Random wakes: delay and sensitivity picked at random
        for (int k = 0; k < 6; k++) begin
            bit dl, em;
            dl = 1'($urandom % 2);
            em = 1'($urandom % 2);
            wr({4'b0, em, 2'b00, dl});
            pulse_clr();
            go_stop();
            repeat (1 + $urandom % 20) @(negedge clk);
            irq_n = 1'b0;
            count_resume(n);
            chk(n == wake_cycles(dl, em), "R2 R3 random wake", n, wake_cycles(dl, em));
            irq_n = 1'b1; repeat (4) @(negedge clk);
            pulse_clr();
        end

        // Reset clears force bit, then random writes against model
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(opt_q == 8'h01, "R4 reset clears force", opt_q, 1);
        rst_n = 1'b1;
        f = 1'b0;
        for (int k = 0; k < 20; k++) begin
            d = 8'($urandom);
            wr(d);
            f = f | d[2];
            chk(opt_q == (d | {5'b0, f, 2'b0}), "R9 R4 random write", opt_q,
                d | {5'b0, f, 2'b0});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule